// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-visible register bank of an asynchronous serial port that has a receive FIFO. It stores the framing mode, the bit-rate divisor, the control word, the FIFO control word and the pin-port word. It keeps the transmit-end, transmit-empty, break and receive-ready status flags, and it drives the transmit and receive interrupt lines. The host reaches it through a simple synchronous port. That port has an 8-bit byte offset and 16-bit data. A write takes effect on the rising clock edge while the write strobe is high. Read data is combinational from the offset.

A write to the transmit data register sends the low byte to a transmitter as a single-cycle strobe. The receive FIFO sits outside this block. It reports its fill count, its head byte, and one-cycle events that set or clear receive-ready. In return the block issues a pop strobe when software reads receive data, a flush strobe, and the trigger-level selection. The status flags follow a clear-by-writing-zero rule. A status read while the transmitter is enabled re-arms the transmit-empty and transmit-end flags for the cycle after the read.

Top module: `sport_regs`

## Requirements
- R1: After reset, the mode word reads 0x00, bit-rate reads 0xFF, control reads 0x20, port reads 0x00 and FIFO control reads 0x0000. Status reads 0x60 (transmit-end bit6 and transmit-empty bit5 set), and both interrupt lines are low.
- R2: Writes keep only the following bits. Mode (0x00) keeps the bits of 0x7B, control (0x08) keeps 0xFA, port (0x20) keeps 0xF3, and bit-rate (0x04) keeps all 8 bits. Each reads back at its own offset, zero-extended to 16 bits.
- R3: The status word (0x10) has transmit-end at bit6, transmit-empty at bit5, break at bit4 and receive-ready at bit1. A status write with one of these bits at 0 clears that flag. A 1 in that bit leaves the flag as it was.
- R4: A write to the transmit data offset (0x0C) clears transmit-empty. In the next cycle, tx_valid is high for exactly one cycle and tx_byte carries the written low byte.
- R5: A status read returns the flags as they stand. If control bit5 (transmit enable) is 1, transmit-empty and transmit-end are both 1 from the following cycle.
- R6: A control write with bit5 at 0 sets transmit-end. tx_irq follows the stored control bit7.
- R7: rx_irq rises after an rxq_rdf_set event while control bit6 is 1. It falls after a control write with bit6 at 0, or after a status write with bit1 or bit0 at 0. An rxq_rdf_set event raises receive-ready whatever bit6 holds.
- R8: rxq_rdf_clr clears receive-ready. It does not touch rx_irq.
- R9: A read of 0x14 with a nonzero FIFO count returns the FIFO head byte and pulses rxq_pop for that cycle. With count 0 it returns 0 and gives no pop. Offset 0x1C returns the FIFO count.
- R10: FIFO control (0x18) stores all 16 bits and reads them back. Its bits 7:6 drive rxq_trig_sel. A write with bit1 at 1 pulses rxq_flush during the write cycle.
- R11: An rxq_brk_set event sets the break flag.
- R12: Reads of 0x24, 0x0C and unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |
| rxq_count | input | 5 | FIFO fill count |
| rxq_data | input | 8 | FIFO head byte |
| rxq_rdf_set | input | 1 | FIFO event: set receive-ready |
| rxq_rdf_clr | input | 1 | FIFO event: clear receive-ready |
| rxq_brk_set | input | 1 | Break detected event |
| rxq_pop | output | 1 | Pop strobe to FIFO |
| rxq_flush | output | 1 | Flush strobe to FIFO |
| rxq_trig_sel | output | 2 | Trigger-level selection |

## Verification
Status writes are tried with all-ones, with one zero bit at a time and with all zeros. These patterns separate a correct write-zero-to-clear rule from an inverted or write-one rule. Status reads are issued with the transmitter enabled and with it disabled, and the flag snapshot is compared with the next read. That tells "return, then re-arm" apart from re-arming before the read and from never re-arming. Receive-ready events are driven with the interrupt enable on and off, and the line is then cleared through each of its separate paths. Writes of all-ones to masked registers expose any wrong mask bit.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;
  localparam int NREG   = 10;

  typedef enum logic [3:0] {
    IX_MODE = 4'd0, IX_BAUD = 4'd1, IX_CTRL = 4'd2, IX_TXD  = 4'd3,
    IX_STAT = 4'd4, IX_RXD  = 4'd5, IX_FCTL = 4'd6, IX_RCNT = 4'd7,
    IX_PORT = 4'd8, IX_LINE = 4'd9
  } reg_ix_e;

  localparam logic [7:0] MODE_KEEP = 8'h7B;
  localparam logic [7:0] CTRL_KEEP = 8'hFA;
  localparam logic [7:0] PORT_KEEP = 8'hF3;

  localparam int B_TEND = 6;
  localparam int B_TDE  = 5;
  localparam int B_BRK  = 4;
  localparam int B_RDF  = 1;
  localparam int B_DR   = 0;

  localparam int C_TIE  = 7;
  localparam int C_RIE  = 6;
  localparam int C_TEN  = 5;
endpackage

// File: rtl/sport_dec.sv
module sport_dec
  import sport_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NSEL = NREG
) (
  input  logic [AW-1:0]   addr,
  output logic [NSEL-1:0] sel
);
  // Registers sit on a 4-byte stride starting at offset 0.
  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    localparam logic [AW-1:0] OFS = AW'(i * 4);
    assign sel[i] = (addr == OFS);
  end
endmodule

// File: rtl/sport_cfg.sv
module sport_cfg
  import sport_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_baud,
  input  logic          wr_ctrl,
  input  logic          wr_port,
  input  logic          wr_fctl,
  input  logic          wr_txd,
  input  logic [DW-1:0] wdata,
  output logic [7:0]    mode_q,
  output logic [7:0]    baud_q,
  output logic [7:0]    ctrl_q,
  output logic [7:0]    port_q,
  output logic [DW-1:0] fctl_q,
  output logic          tx_valid,
  output logic [7:0]    tx_byte
);
  logic [7:0]    mode_d, baud_d, ctrl_d, port_d, txb_d;
  logic [DW-1:0] fctl_d;
  logic          txv_d;

  always_comb begin
    mode_d = wr_mode ? (wdata[7:0] & MODE_KEEP) : mode_q;
    baud_d = wr_baud ? wdata[7:0]               : baud_q;
    ctrl_d = wr_ctrl ? (wdata[7:0] & CTRL_KEEP) : ctrl_q;
    port_d = wr_port ? (wdata[7:0] & PORT_KEEP) : port_q;
    fctl_d = wr_fctl ? wdata                    : fctl_q;
    txv_d  = wr_txd;
    txb_d  = wr_txd ? wdata[7:0] : tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 8'h00;
      baud_q   <= 8'hFF;
      ctrl_q   <= 8'h20;
      port_q   <= 8'h00;
      fctl_q   <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
    end else begin
      mode_q   <= mode_d;
      baud_q   <= baud_d;
      ctrl_q   <= ctrl_d;
      port_q   <= port_d;
      fctl_q   <= fctl_d;
      tx_valid <= txv_d;
      tx_byte  <= txb_d;
    end
  end

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> (tx_valid && tx_byte == $past(wdata[7:0]))) else $error("tx strobe"); // R4
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_txd |=> !tx_valid) else $error("tx idle"); // R4
  AST_MODE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~MODE_KEEP) == 8'h00) else $error("mode mask"); // R2
endmodule

// File: rtl/sport_flags.sv
module sport_flags
  import sport_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_ctrl,
  input  logic          wr_txd,
  input  logic          rd_stat,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          rie,
  input  logic          rdf_set,
  input  logic          rdf_clr,
  input  logic          brk_set,
  output logic [7:0]    stat_word,
  output logic          rx_irq
);
  logic tend_q, tde_q, brk_q, rdf_q;
  logic tend_d, tde_d, brk_d, rdf_d, irq_d;

  always_comb begin
    tend_d = tend_q;
    tde_d  = tde_q;
    brk_d  = brk_q;
    rdf_d  = rdf_q;
    irq_d  = rx_irq;
    // write-zero-to-clear on the status word
    if (wr_stat) begin
      if (!wdata[B_TEND]) tend_d = 1'b0;
      if (!wdata[B_TDE])  tde_d  = 1'b0;
      if (!wdata[B_BRK])  brk_d  = 1'b0;
      if (!wdata[B_RDF])  rdf_d  = 1'b0;
      if (!wdata[B_RDF] || !wdata[B_DR]) irq_d = 1'b0;
    end
    if (wr_ctrl && !wdata[C_TEN]) tend_d = 1'b1;
    if (wr_txd)                   tde_d  = 1'b0;
    if (rdf_clr)                  rdf_d  = 1'b0;
    // hardware events win over software clears in the same cycle
    if (rdf_set) begin
      rdf_d = 1'b1;
      if (rie) irq_d = 1'b1;
    end
    if (brk_set)                  brk_d  = 1'b1;
    if (wr_ctrl && !wdata[C_RIE]) irq_d  = 1'b0;
    // re-arm after the read value has been delivered
    if (rd_stat && tx_en) begin
      tde_d  = 1'b1;
      tend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      tde_q  <= 1'b1;
      brk_q  <= 1'b0;
      rdf_q  <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tend_q <= tend_d;
      tde_q  <= tde_d;
      brk_q  <= brk_d;
      rdf_q  <= rdf_d;
      rx_irq <= irq_d;
    end
  end

  always_comb begin
    stat_word         = 8'h00;
    stat_word[B_TEND] = tend_q;
    stat_word[B_TDE]  = tde_q;
    stat_word[B_BRK]  = brk_q;
    stat_word[B_RDF]  = rdf_q;
  end

  AST_TDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !rd_stat) |=> !tde_q) else $error("tde"); // R4
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && tx_en) |=> (tde_q && tend_q)) else $error("rearm"); // R5
  AST_CTRL_TEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[C_TEN]) |=> tend_q) else $error("tend"); // R6
  AST_RIRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rie) else $error("rx irq gate"); // R7
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |=> brk_q) else $error("brk"); // R11
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          tx_irq,
  output logic          rx_irq,
  input  logic [CW-1:0] rxq_count,
  input  logic [7:0]    rxq_data,
  input  logic          rxq_rdf_set,
  input  logic          rxq_rdf_clr,
  input  logic          rxq_brk_set,
  output logic          rxq_pop,
  output logic          rxq_flush,
  output logic [1:0]    rxq_trig_sel
);
  logic [NREG-1:0] sel, wsel, rsel;
  logic [7:0]      mode_q, baud_q, ctrl_q, port_q, stat_word;
  logic [DW-1:0]   fctl_q;
  logic            rxq_nonempty;

  sport_dec #(.AW(AW), .NSEL(NREG)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wsel = sel & {NREG{bus_wr}};
  assign rsel = sel & {NREG{bus_rd}};

  sport_cfg #(.DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mode  (wsel[IX_MODE]),
    .wr_baud  (wsel[IX_BAUD]),
    .wr_ctrl  (wsel[IX_CTRL]),
    .wr_port  (wsel[IX_PORT]),
    .wr_fctl  (wsel[IX_FCTL]),
    .wr_txd   (wsel[IX_TXD]),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .baud_q   (baud_q),
    .ctrl_q   (ctrl_q),
    .port_q   (port_q),
    .fctl_q   (fctl_q),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte)
  );

  sport_flags #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stat   (wsel[IX_STAT]),
    .wr_ctrl   (wsel[IX_CTRL]),
    .wr_txd    (wsel[IX_TXD]),
    .rd_stat   (rsel[IX_STAT]),
    .wdata     (bus_wdata),
    .tx_en     (ctrl_q[C_TEN]),
    .rie       (ctrl_q[C_RIE]),
    .rdf_set   (rxq_rdf_set),
    .rdf_clr   (rxq_rdf_clr),
    .brk_set   (rxq_brk_set),
    .stat_word (stat_word),
    .rx_irq    (rx_irq)
  );

  assign tx_irq       = ctrl_q[C_TIE];
  assign rxq_nonempty = (rxq_count != '0);
  assign rxq_pop      = rsel[IX_RXD] && rxq_nonempty;
  assign rxq_flush    = wsel[IX_FCTL] && bus_wdata[1];
  assign rxq_trig_sel = fctl_q[7:6];

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel[IX_MODE]: bus_rdata = DW'(mode_q);
      sel[IX_BAUD]: bus_rdata = DW'(baud_q);
      sel[IX_CTRL]: bus_rdata = DW'(ctrl_q);
      sel[IX_STAT]: bus_rdata = DW'(stat_word);
      sel[IX_RXD]:  bus_rdata = rxq_nonempty ? DW'(rxq_data) : '0;
      sel[IX_FCTL]: bus_rdata = fctl_q;
      sel[IX_RCNT]: bus_rdata = DW'(rxq_count);
      sel[IX_PORT]: bus_rdata = DW'(port_q);
      default:      bus_rdata = '0;
    endcase
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> (rxq_count != '0)) else $error("pop empty"); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)) else $error("decode"); // R12
endmodule

// File: tb/sim_sport_regs.sv
module sim_sport_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        tx_valid, tx_irq, rx_irq;
  logic [7:0]  tx_byte;
  logic [4:0]  rxq_count;
  logic [7:0]  rxq_data;
  logic        rxq_rdf_set, rxq_rdf_clr, rxq_brk_set;
  logic        rxq_pop, rxq_flush;
  logic [1:0]  rxq_trig_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sport_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rxq_count(rxq_count), .rxq_data(rxq_data), .rxq_rdf_set(rxq_rdf_set),
    .rxq_rdf_clr(rxq_rdf_clr), .rxq_brk_set(rxq_brk_set), .rxq_pop(rxq_pop),
    .rxq_flush(rxq_flush), .rxq_trig_sel(rxq_trig_sel)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    if (which == 0) rxq_rdf_set = 1'b1;
    if (which == 1) rxq_rdf_clr = 1'b1;
    if (which == 2) rxq_brk_set = 1'b1;
    @(negedge clk);
    rxq_rdf_set = 1'b0; rxq_rdf_clr = 1'b0; rxq_brk_set = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(8'h00, v); check("R1 mode", v, 16'h0000);
    rd(8'h04, v); check("R1 baud", v, 16'h00FF);
    rd(8'h08, v); check("R1 ctrl", v, 16'h0020);
    rd(8'h20, v); check("R1 port", v, 16'h0000);
    rd(8'h18, v); check("R1 fctl", v, 16'h0000);
    rd(8'h10, v); check("R1 stat", v, 16'h0060);
    check("R1 irqs", {14'h0, tx_irq, rx_irq}, 16'h0000);
  endtask

  task automatic t_masks;
    logic [15:0] v;
    wr(8'h00, 16'hFFFF); rd(8'h00, v); check("R2 mode mask", v, 16'h007B);
    wr(8'h04, 16'h1234); rd(8'h04, v); check("R2 baud", v, 16'h0034);
    wr(8'h20, 16'hFFFF); rd(8'h20, v); check("R2 port mask", v, 16'h00F3);
    wr(8'h08, 16'hFFFF); rd(8'h08, v); check("R2 ctrl mask", v, 16'h00FA);
    check("R6 tx_irq on", {15'h0, tx_irq}, 16'h0001);
    wr(8'h08, 16'h0020);
    check("R6 tx_irq off", {15'h0, tx_irq}, 16'h0000);
  endtask

  task automatic t_status_rw;
    logic [15:0] v;
    pulse_ev(2);                      // R11 set break
    pulse_ev(0);                      // set receive-ready
    rd(8'h10, v); check("R11 brk set", v & 16'h0012, 16'h0012);
    wr(8'h10, 16'hFFFF);
    rd(8'h10, v); check("R3 write ones keep", v, 16'h0072);
    wr(8'h10, 16'hFFEF);
    rd(8'h10, v); check("R3 clear brk only", v, 16'h0062);
    wr(8'h10, 16'hFFFD);
    rd(8'h10, v); check("R3 clear rdf only", v, 16'h0060);
    wr(8'h10, 16'h0000);
    rd(8'h10, v); check("R5 read before rearm", v, 16'h0000);
    rd(8'h10, v); check("R5 rearm after read", v, 16'h0060);
  endtask

  task automatic t_tx;
    logic [15:0] v;
    wr(8'h0C, 16'hBEA7);
    check("R4 strobe", {7'h0, tx_valid, tx_byte}, 16'h01A7);
    @(negedge clk); #1;
    check("R4 strobe one cycle", {15'h0, tx_valid}, 16'h0000);
    wr(8'h08, 16'h0000);              // transmitter off, sets TEND
    rd(8'h10, v); check("R4 tde cleared", v, 16'h0040);
    wr(8'h10, 16'h0000);
    rd(8'h10, v); check("R5 no rearm disabled", v, 16'h0000);
    rd(8'h10, v); check("R5 still none", v, 16'h0000);
    wr(8'h08, 16'h0000);
    rd(8'h10, v); check("R6 ctrl sets tend", v, 16'h0040);
    wr(8'h08, 16'h0020);
  endtask

  task automatic t_rx_irq;
    logic [15:0] v;
    pulse_ev(0);
    check("R7 no irq when disabled", {15'h0, rx_irq}, 16'h0000);
    rd(8'h10, v); check("R7 rdf set anyway", v & 16'h0002, 16'h0002);
    pulse_ev(1);
    rd(8'h10, v); check("R8 rdf cleared", v & 16'h0002, 16'h0000);
    wr(8'h08, 16'h0060);
    pulse_ev(0);
    check("R7 irq raised", {15'h0, rx_irq}, 16'h0001);
    pulse_ev(1);
    check("R8 clr keeps irq", {15'h0, rx_irq}, 16'h0001);
    wr(8'h10, 16'hFFFE);
    check("R7 dr-zero drops irq", {15'h0, rx_irq}, 16'h0000);
    pulse_ev(0);
    wr(8'h10, 16'hFFFD);
    check("R7 rdf-zero drops irq", {15'h0, rx_irq}, 16'h0000);
    pulse_ev(0);
    wr(8'h08, 16'h0020);
    check("R7 rie-off drops irq", {15'h0, rx_irq}, 16'h0000);
  endtask

  task automatic t_fifo;
    logic [15:0] v;
    rxq_count = 5'd3; rxq_data = 8'hA5;
    @(negedge clk);
    bus_addr = 8'h14; bus_rd = 1'b1;
    #1 check("R9 rx data", bus_rdata, 16'h00A5);
    check("R9 pop", {15'h0, rxq_pop}, 16'h0001);
    @(negedge clk); bus_rd = 1'b0;
    rd(8'h1C, v); check("R9 count", v, 16'h0003);
    rxq_count = 5'd0;
    @(negedge clk);
    bus_addr = 8'h14; bus_rd = 1'b1;
    #1 check("R9 empty data", bus_rdata, 16'h0000);
    check("R9 empty no pop", {15'h0, rxq_pop}, 16'h0000);
    @(negedge clk); bus_rd = 1'b0;
    @(negedge clk);
    bus_addr = 8'h18; bus_wdata = 16'h81C2; bus_wr = 1'b1;
    #1 check("R10 flush pulse", {15'h0, rxq_flush}, 16'h0001);
    @(negedge clk); bus_wr = 1'b0;
    #1 check("R10 trig", {14'h0, rxq_trig_sel}, 16'h0003);
    rd(8'h18, v); check("R10 fctl read", v, 16'h81C2);
    @(negedge clk);
    bus_addr = 8'h18; bus_wdata = 16'h0040; bus_wr = 1'b1;
    #1 check("R10 no flush", {15'h0, rxq_flush}, 16'h0000);
    @(negedge clk); bus_wr = 1'b0;
    #1 check("R10 trig 1", {14'h0, rxq_trig_sel}, 16'h0001);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    wr(8'h00, 16'h0012);
    wr(8'h30, 16'hFFFF);
    wr(8'h24, 16'hFFFF);
    wr(8'h02, 16'hFFFF);
    rd(8'h00, v); check("R12 mode intact", v, 16'h0012);
    rd(8'h08, v); check("R12 ctrl intact", v, 16'h0020);
    rd(8'h24, v); check("R12 line reads 0", v, 16'h0000);
    rd(8'h30, v); check("R12 unmapped 0", v, 16'h0000);
    rd(8'h0C, v); check("R12 txd reads 0", v, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxq_count = '0; rxq_data = '0;
    rxq_rdf_set = 1'b0; rxq_rdf_clr = 1'b0; rxq_brk_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_masks;
    t_status_rw;
    t_tx;
    t_rx_irq;
    t_fifo;
    t_unmapped;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule